// File: doc/BRIEF.md
# LED serial stream transmitter

This block holds the indicator state of up to eight drive ports, with three lamps per port: activity, locate and fault. It sends the whole state to an external LED controller over three wires: a serial clock, a load strobe and a data line. A host update names a logical port and gives its three lamp flags. A small table maps each logical port to a physical slot in the serial pattern, and the update rewrites only that slot's three bits.

Each update starts a full retransmission. A frame begins with a number of idle clock pulses. One pulse follows with the load strobe high. Then come three data bits per configured port, least significant pattern bit first, and last a number of trailing idle pulses. Every pulse is high for a programmable number of system clock cycles and then low for the same number. Data and load change only on a falling edge. An update that arrives while a frame is being sent goes into the pattern at once and causes exactly one more frame when the current one ends. The configuration (idle counts and port count) is sampled when a frame starts.

Top module: `led_serial_tx`

## Requirements
- R1: After reset ser_clk, ser_load, ser_data and busy are 0, the pattern is all zero and the table maps every port p to slot p.
- R2: Port state sits at pattern bit 3*slot+0 (activity), 3*slot+1 (locate) and 3*slot+2 (fault). An update writes all three bits of its slot and leaves every other bit unchanged.
- R3: A table write (map_we) sets the slot of map_port to map_slot. An update uses the table entry current in its cycle, so a write and an update in the same cycle use the old entry.
- R4: A frame is cfg_pre pulses with load and data low, then one pulse with load high and data low, then 3*N pulses carrying pattern bits 0 upward, then cfg_post pulses with load and data low.
- R5: A frame opens with HALF_CYC cycles of ser_clk low. Each pulse is then HALF_CYC cycles high followed by HALF_CYC cycles low. ser_clk is low whenever busy is low.
- R6: ser_data and ser_load change only on a falling edge of ser_clk (or at frame start, while ser_clk is low) and hold steady while ser_clk is high.
- R7: N is cfg_nports clamped to PORTS. cfg_pre, cfg_post and cfg_nports are sampled when a frame starts, so changes during a frame take effect from the next frame.
- R8: Updates during a frame enter the pattern immediately and produce exactly one further frame, which carries the latest pattern.
- R9: busy rises two cycles after an update that finds the block idle and stays high until the last low phase ends. An update in the cycle a frame starts is not lost: it causes one further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Lamp update strobe |
| upd_port | input | 3 | Logical port of the update |
| upd_act | input | 1 | Activity lamp flag |
| upd_loc | input | 1 | Locate lamp flag |
| upd_flt | input | 1 | Fault lamp flag |
| map_we | input | 1 | Port-to-slot table write strobe |
| map_port | input | 3 | Table entry to write |
| map_slot | input | 3 | Slot value written |
| cfg_pre | input | 8 | Idle pulses before the load pulse |
| cfg_post | input | 8 | Idle pulses after the data |
| cfg_nports | input | 4 | Ports sent per frame (clamped to 8) |
| ser_clk | output | 1 | Serial clock |
| ser_load | output | 1 | Load strobe |
| ser_data | output | 1 | Serial data |
| busy | output | 1 | Frame in progress |

## Verification
Two pairs of events can land in one cycle. First, a frame can start in the same edge that accepts a new update. The bench sends two updates on back-to-back cycles, so the second arrives exactly when the first one's frame starts. It expects two frames: the first carries only the first change and the second carries both. Second, a table write can coincide with an update to the same port. The bench expects the bits at the old slot and then confirms through later frames that the new slot is used from then on. Each received frame is compared pulse by pulse with a pattern the bench builds from its own model.

// File: rtl/led_serial_pkg.sv
package led_serial_pkg;
  localparam int unsigned LEDS_PER_PORT = 3;

  typedef enum logic [1:0] {
    PH_LEAD = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } ser_phase_e;

  // bit 0 activity, bit 1 locate, bit 2 fault
  typedef struct packed {
    logic fault;
    logic locate;
    logic activity;
  } led_flags_t;
endpackage

// File: rtl/led_slot_table.sv
module led_slot_table #(
  parameter int PORTS  = 8,
  parameter int PORT_W = 3,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [PORT_W-1:0] rd_port,
  output logic [SLOT_W-1:0] rd_slot
);
  logic [SLOT_W-1:0] tbl [PORTS];

  // identity mapping after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PORTS; i++) tbl[i] <= SLOT_W'(i);
    end else if (we && int'(wr_port) < PORTS) begin
      tbl[wr_port] <= wr_slot;
    end
  end

  assign rd_slot = (int'(rd_port) < PORTS) ? tbl[rd_port] : '0;
endmodule

// File: rtl/led_pattern_store.sv
module led_pattern_store import led_serial_pkg::*; #(
  parameter int PORTS  = 8,
  parameter int SLOT_W = 3,
  parameter int PAT_W  = 3 * PORTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [SLOT_W-1:0] upd_slot,
  input  led_flags_t        upd_flags,
  input  logic              take,
  output logic [PAT_W-1:0]  pattern,
  output logic              pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pattern <= '0;
      pending <= 1'b0;
    end else begin
      for (int s = 0; s < PORTS; s++) begin
        if (upd_valid && int'(upd_slot) == s)
          pattern[LEDS_PER_PORT*s +: LEDS_PER_PORT] <= upd_flags;
      end
      // a new update wins over the frame start that consumes the old one
      pending <= upd_valid | (pending & ~take);
    end
  end
endmodule

// File: rtl/led_frame_shifter.sv
module led_frame_shifter import led_serial_pkg::*; #(
  parameter int PORTS    = 8,
  parameter int PAT_W    = 24,
  parameter int HALF_CYC = 4,
  parameter int CNT_W    = 8,
  parameter int NP_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic [PAT_W-1:0] pattern,
  input  logic [CNT_W-1:0] cfg_pre,
  input  logic [CNT_W-1:0] cfg_post,
  input  logic [NP_W-1:0]  cfg_nports,
  output logic             take,
  output logic             ser_clk,
  output logic             ser_load,
  output logic             ser_data,
  output logic             busy
);
  localparam int HC_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int IDX_W = $clog2(2 * (1 << CNT_W) + PAT_W + 2);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

  logic             active;
  ser_phase_e       ph;
  logic [HC_W-1:0]  hc;
  logic [IDX_W-1:0] q, pre_q, dend_q, last_q;
  logic             fin;
  logic [PAT_W-1:0] sh;

  logic [NP_W-1:0]  np_eff;
  logic [IDX_W-1:0] ndat, nq;

  always_comb begin
    np_eff = (int'(cfg_nports) > PORTS) ? NP_W'(PORTS) : cfg_nports;
    ndat   = IDX_W'(LEDS_PER_PORT) * IDX_W'(np_eff);
    nq     = q + IDX_W'(1);
  end

  assign take = pending & ~active;
  assign busy = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      ph       <= PH_LEAD;
      hc       <= '0;
      q        <= '0;
      pre_q    <= '0;
      dend_q   <= '0;
      last_q   <= '0;
      fin      <= 1'b0;
      sh       <= '0;
      ser_clk  <= 1'b0;
      ser_load <= 1'b0;
      ser_data <= 1'b0;
    end else if (!active) begin
      if (pending) begin
        active   <= 1'b1;
        ph       <= PH_LEAD;
        hc       <= '0;
        q        <= '0;
        fin      <= 1'b0;
        pre_q    <= IDX_W'(cfg_pre);
        dend_q   <= IDX_W'(cfg_pre) + ndat;
        last_q   <= IDX_W'(cfg_pre) + ndat + IDX_W'(cfg_post);
        sh       <= pattern;
        ser_clk  <= 1'b0;
        ser_load <= (cfg_pre == '0);
        ser_data <= 1'b0;
      end
    end else if (hc != HC_LAST) begin
      hc <= hc + 1'b1;
    end else begin
      hc <= '0;
      unique case (ph)
        PH_LEAD: begin
          ph      <= PH_HIGH;
          ser_clk <= 1'b1;
        end
        PH_HIGH: begin
          ph      <= PH_LOW;
          ser_clk <= 1'b0;
          q       <= nq;
          if (q == last_q) begin
            fin      <= 1'b1;
            ser_load <= 1'b0;
            ser_data <= 1'b0;
          end else begin
            ser_load <= (nq == pre_q);
            if (nq > pre_q && nq <= dend_q) begin
              ser_data <= sh[0];
              sh       <= sh >> 1;
            end else begin
              ser_data <= 1'b0;
            end
          end
        end
        PH_LOW: begin
          if (fin) begin
            active <= 1'b0;
            ph     <= PH_LEAD;
          end else begin
            ph      <= PH_HIGH;
            ser_clk <= 1'b1;
          end
        end
        default: ph <= PH_LEAD;
      endcase
    end
  end
endmodule

// File: rtl/led_serial_tx.sv
module led_serial_tx import led_serial_pkg::*; #(
  parameter int PORTS    = 8,
  parameter int PORT_W   = $clog2(PORTS),
  parameter int SLOT_W   = PORT_W,
  parameter int NP_W     = PORT_W + 1,
  parameter int CNT_W    = 8,
  parameter int HALF_CYC = 6250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [PORT_W-1:0] upd_port,
  input  logic              upd_act,
  input  logic              upd_loc,
  input  logic              upd_flt,
  input  logic              map_we,
  input  logic [PORT_W-1:0] map_port,
  input  logic [SLOT_W-1:0] map_slot,
  input  logic [CNT_W-1:0]  cfg_pre,
  input  logic [CNT_W-1:0]  cfg_post,
  input  logic [NP_W-1:0]   cfg_nports,
  output logic              ser_clk,
  output logic              ser_load,
  output logic              ser_data,
  output logic              busy
);
  localparam int PAT_W = LEDS_PER_PORT * PORTS;

  logic [SLOT_W-1:0] upd_slot;
  led_flags_t        flags;
  logic [PAT_W-1:0]  pattern;
  logic              pending, take;

  always_comb begin
    flags.activity = upd_act;
    flags.locate   = upd_loc;
    flags.fault    = upd_flt;
  end

  led_slot_table #(.PORTS(PORTS), .PORT_W(PORT_W), .SLOT_W(SLOT_W)) u_map (
    .clk(clk), .rst(rst), .we(map_we), .wr_port(map_port), .wr_slot(map_slot),
    .rd_port(upd_port), .rd_slot(upd_slot)
  );

  led_pattern_store #(.PORTS(PORTS), .SLOT_W(SLOT_W), .PAT_W(PAT_W)) u_pat (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_slot(upd_slot),
    .upd_flags(flags), .take(take), .pattern(pattern), .pending(pending)
  );

  led_frame_shifter #(.PORTS(PORTS), .PAT_W(PAT_W), .HALF_CYC(HALF_CYC),
                      .CNT_W(CNT_W), .NP_W(NP_W)) u_frm (
    .clk(clk), .rst(rst), .pending(pending), .pattern(pattern),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_nports(cfg_nports),
    .take(take), .ser_clk(ser_clk), .ser_load(ser_load), .ser_data(ser_data),
    .busy(busy)
  );
endmodule

// File: rtl/led_serial_tx_chk.sv
module led_serial_tx_chk #(
  parameter int HALF_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic ser_clk,
  input logic ser_load,
  input logic ser_data,
  input logic busy
);
  logic [31:0] hi_cnt, lo_cnt, ld_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      ld_cnt <= '0;
    end else begin
      hi_cnt <= ser_clk ? hi_cnt + 1 : '0;
      lo_cnt <= (busy && !ser_clk) ? lo_cnt + 1 : '0;
      ld_cnt <= ser_load ? ld_cnt + 1 : '0;
    end
  end

  // R1: outputs quiet while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ser_clk && !ser_load && !ser_data));

  // R5: high phase never longer than HALF_CYC
  a_r5_high_width: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> (hi_cnt < HALF_CYC));

  // R5: low phase inside a frame never longer than HALF_CYC
  a_r5_low_width: assert property (@(posedge clk) disable iff (rst)
    (busy && !ser_clk) |-> (lo_cnt < HALF_CYC));

  // R6: data and load steady while the serial clock is high
  a_r6_hold_high: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> ($stable(ser_data) && $stable(ser_load)));

  // R4: load lasts exactly one pulse period at most
  a_r4_load_single: assert property (@(posedge clk) disable iff (rst)
    ser_load |-> (ld_cnt < 2 * HALF_CYC));
endmodule

bind led_serial_tx led_serial_tx_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_load(ser_load),
  .ser_data(ser_data), .busy(busy)
);

// File: tb/led_serial_tx_bench.sv
module led_serial_tx_bench;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_valid = 1'b0, upd_act = 1'b0, upd_loc = 1'b0, upd_flt = 1'b0;
  logic [2:0] upd_port = '0;
  logic map_we = 1'b0;
  logic [2:0] map_port = '0, map_slot = '0;
  logic [7:0] cfg_pre = '0, cfg_post = '0;
  logic [3:0] cfg_nports = 4'd8;
  logic ser_clk, ser_load, ser_data, busy;

  always #4 clk = ~clk;

  led_serial_tx #(.HALF_CYC(HALF)) u_led_serial_tx (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_port(upd_port),
    .upd_act(upd_act), .upd_loc(upd_loc), .upd_flt(upd_flt),
    .map_we(map_we), .map_port(map_port), .map_slot(map_slot),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_nports(cfg_nports),
    .ser_clk(ser_clk), .ser_load(ser_load), .ser_data(ser_data), .busy(busy)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model
  logic [2:0]  mmap [8];
  logic [23:0] mpat;

  // frame capture
  int fc = 0;
  int f_n [64];
  int f_werr [64];
  int f_herr [64];
  logic [127:0] f_load [64];
  logic [127:0] f_data [64];
  int cur_n, lowcnt, hicnt, werr, herr;
  logic [127:0] cap_load, cap_data;
  logic prev_clk = 1'b0, prev_busy = 1'b0, prev_load = 1'b0, prev_data = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      prev_clk = 1'b0; prev_busy = 1'b0;
    end else begin
      if (busy && !prev_busy) begin
        cur_n = 0; lowcnt = 0; hicnt = 0; werr = 0; herr = 0;
        cap_load = '0; cap_data = '0;
      end
      if (busy) begin
        if (ser_clk) begin
          if (!prev_clk) begin
            if (lowcnt != HALF) werr++;
            if (ser_data != prev_data || ser_load != prev_load) herr++;
            if (cur_n < 128) begin
              cap_load[cur_n] = ser_load;
              cap_data[cur_n] = ser_data;
            end
            cur_n++;
          end else if (ser_data != prev_data || ser_load != prev_load) begin
            herr++;
          end
          hicnt++;
          lowcnt = 0;
        end else begin
          if (prev_clk) begin
            if (hicnt != HALF) werr++;
            hicnt = 0;
          end
          lowcnt++;
        end
      end
      if (!busy && prev_busy) begin
        if (lowcnt != HALF) werr++;
        if (fc < 64) begin
          f_n[fc] = cur_n; f_werr[fc] = werr; f_herr[fc] = herr;
          f_load[fc] = cap_load; f_data[fc] = cap_data;
        end
        fc++;
      end
      prev_clk = ser_clk; prev_busy = busy;
      prev_load = ser_load; prev_data = ser_data;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_frame(input int k, input int pre, input int post,
                             input int n, input logic [23:0] pat, input string req);
    int ne, total;
    logic [127:0] el, ed;
    ne = (n > 8) ? 8 : n;
    total = pre + 1 + 3 * ne + post;
    el = '0; ed = '0;
    el[pre] = 1'b1;
    for (int i = 0; i < 3 * ne; i++) ed[pre + 1 + i] = pat[i];
    chk(f_n[k] == total, req, "pulse count", longint'(f_n[k]), longint'(total));
    chk(f_load[k] == el, "R4", "load position", longint'(f_load[k][63:0]), longint'(el[63:0]));
    chk(f_data[k] == ed, req, "data bits", longint'(f_data[k][63:0]), longint'(ed[63:0]));
    chk(f_werr[k] == 0, "R5", "pulse width errors", longint'(f_werr[k]), 0);
    chk(f_herr[k] == 0, "R6", "hold errors", longint'(f_herr[k]), 0);
  endtask

  task automatic set_cfg(input int pre, input int post, input int n);
    @(negedge clk);
    cfg_pre = 8'(pre); cfg_post = 8'(post); cfg_nports = 4'(n);
  endtask

  task automatic do_update(input int p, input bit a, input bit l, input bit f);
    @(negedge clk);
    upd_valid = 1'b1; upd_port = 3'(p); upd_act = a; upd_loc = l; upd_flt = f;
    mpat[3 * mmap[p] +: 3] = {f, l, a};
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic map_write(input int p, input int s);
    @(negedge clk);
    map_we = 1'b1; map_port = 3'(p); map_slot = 3'(s);
    mmap[p] = 3'(s);
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    while (fc < target || busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, pre, post, n;
    logic [23:0] p1;
    int unsigned sd;
    sd = $urandom(32'd7351);
    for (int i = 0; i < 8; i++) mmap[i] = 3'(i);
    mpat = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!ser_clk && !ser_load && !ser_data && !busy, "R1", "outputs after reset",
        longint'({ser_clk, ser_load, ser_data, busy}), 0);

    // R1/R2/R9: identity map, activity bit of port 5, busy latency
    base = fc;
    do_update(5, 1'b1, 1'b0, 1'b0);
    chk(!busy, "R9", "busy one cycle after update", longint'(busy), 0);
    @(negedge clk);
    chk(busy, "R9", "busy two cycles after update", longint'(busy), 1);
    wait_frames(base + 1);
    check_frame(base, 0, 0, 8, 24'h008000, "R1");

    // R4 idle pulses around a short frame; R2 multi-bit
    set_cfg(2, 3, 4);
    base = fc;
    do_update(1, 1'b0, 1'b1, 1'b1);
    wait_frames(base + 1);
    check_frame(base, 2, 3, 4, mpat, "R2");

    // R7 clamp
    set_cfg(1, 0, 12);
    base = fc;
    do_update(7, 1'b1, 1'b1, 1'b1);
    wait_frames(base + 1);
    check_frame(base, 1, 0, 12, mpat, "R7");

    // R3 table write, then update
    map_write(2, 7);
    base = fc;
    do_update(2, 1'b0, 1'b0, 1'b1);
    wait_frames(base + 1);
    check_frame(base, 1, 0, 8, mpat, "R3");

    // R3 same-cycle table write and update: old entry used
    base = fc;
    @(negedge clk);
    map_we = 1'b1; map_port = 3'd3; map_slot = 3'd0;
    upd_valid = 1'b1; upd_port = 3'd3; upd_act = 1'b1; upd_loc = 1'b0; upd_flt = 1'b0;
    mpat[9 +: 3] = 3'b001;
    mmap[3] = 3'd0;
    @(negedge clk);
    map_we = 1'b0; upd_valid = 1'b0;
    wait_frames(base + 1);
    chk(f_data[base][2 + 9] == 1'b1 && f_data[base][2] == 1'b0, "R3",
        "same-cycle map/update slot", longint'(f_data[base][63:0]), longint'({mpat, 2'b00}));
    check_frame(base, 1, 0, 8, mpat, "R3");
    base = fc;
    do_update(3, 1'b0, 1'b1, 1'b0);
    wait_frames(base + 1);
    check_frame(base, 1, 0, 8, mpat, "R3");

    // R2 clear all three bits of port 5, others unchanged
    base = fc;
    do_update(5, 1'b0, 1'b0, 1'b0);
    wait_frames(base + 1);
    check_frame(base, 1, 0, 8, mpat, "R2");

    // R9 update in the frame-start cycle
    set_cfg(0, 1, 8);
    base = fc;
    @(negedge clk);
    upd_valid = 1'b1; upd_port = 3'd0; upd_act = 1'b1; upd_loc = 1'b0; upd_flt = 1'b1;
    mpat[3 * mmap[0] +: 3] = 3'b101;
    p1 = mpat;
    @(negedge clk);
    upd_port = 3'd4; upd_act = 1'b0; upd_loc = 1'b1; upd_flt = 1'b0;
    mpat[3 * mmap[4] +: 3] = 3'b010;
    @(negedge clk);
    upd_valid = 1'b0;
    wait_frames(base + 2);
    repeat (40) @(negedge clk);
    chk(fc == base + 2, "R9", "frames after start-cycle update", longint'(fc - base), 2);
    check_frame(base, 0, 1, 8, p1, "R9");
    check_frame(base + 1, 0, 1, 8, mpat, "R9");

    // R8 merge of mid-frame updates; R7 config sampled at start
    set_cfg(1, 0, 8);
    base = fc;
    do_update(6, 1'b1, 1'b0, 1'b0);
    p1 = mpat;
    while (!busy) @(negedge clk);
    repeat (15) @(negedge clk);
    cfg_pre = 8'd2;
    do_update(6, 1'b0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    do_update(1, 1'b1, 1'b0, 1'b0);
    wait_frames(base + 2);
    repeat (40) @(negedge clk);
    chk(fc == base + 2, "R8", "frames after mid-frame updates", longint'(fc - base), 2);
    check_frame(base, 1, 0, 8, p1, "R7");
    check_frame(base + 1, 2, 0, 8, mpat, "R8");

    // random updates, table writes and configurations
    for (int it = 0; it < 30; it++) begin
      if ($urandom % 4 == 0) map_write(int'($urandom % 8), int'($urandom % 8));
      pre = int'($urandom % 4);
      post = int'($urandom % 4);
      n = 1 + int'($urandom % 10);
      set_cfg(pre, post, n);
      base = fc;
      do_update(int'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom));
      wait_frames(base + 1);
      check_frame(base % 64, pre, post, n, mpat, "R4");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule